// File: doc/BRIEF.md
# Minute-Resolution Event-Kicked Watchdog

This block is a watchdog timer whose count is kept in whole minutes. A one-minute strobe comes from outside the block. A host programs an 8-bit time-out through a small register port. A non-zero value loads the counter and starts the countdown. A value of zero turns the watchdog off. When the count runs out, the counter halts and a time-out status flag is raised. That flag can also be routed to an interrupt output.

Nothing in software kicks the watchdog. The only thing that restarts it is system activity: a keyboard interrupt, a mouse interrupt, or an access to the joystick port. Each of these sources has its own enable. An enabled source reloads the counter from the programmed value and clears the status flag. Separately, the host may write the status flag directly at any time, whatever the counter is doing.

Top module: `wdt_top`

## Requirements
- R1: While the count is non-zero, each cycle with `minute_tick` high lowers the count by one. The countdown therefore spans exactly N ticks, where N is the loaded value, from 1 to 255.
- R2: After reset, the value register, status, configuration and `wdt_irq` are all zero. Writing 0 to the value register stops the counter, so later ticks never raise the status.
- R3: Writing a non-zero value to address 0 loads the counter with that value and starts the countdown at once, replacing any count already in progress.
- R4: The tick that takes the count from 1 to 0 sets `timeout_status` on the following cycle.
- R5: A write to address 1 sets the status to wdata bit 0. This applies in every counter state, and it wins over a reload or an expiry in the same cycle.
- R6: Activity events act only on a 0-to-1 transition of their input. An input held high acts once.
- R7: An enabled event reloads the counter from the value register and clears the status. A rising edge on a disabled event changes nothing.
- R8: Configuration bit 1 enables the joystick-access event, bit 2 enables the keyboard event and bit 3 enables the mouse event.
- R9: `wdt_irq` is high exactly when the status is set and configuration bit 0 is set.
- R10: After a time-out, the counter stays stopped until a value write or an enabled event reloads it. A reload in the same cycle as a tick wins over the decrement.
- R11: Reads are combinational. Address 0 returns the value, address 1 returns the status in bit 0, address 2 returns the configuration in bits 3:0, and address 3 returns 0. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| minute_tick | input | 1 | One-cycle strobe, once per minute |
| kbd_irq | input | 1 | Keyboard interrupt activity |
| mouse_irq | input | 1 | Mouse interrupt activity |
| joy_access | input | 1 | Joystick-port access activity |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| timeout_status | output | 1 | Time-out status flag |
| wdt_irq | output | 1 | Routed time-out interrupt |

## Verification
The bench builds the block with its default 8-bit count and data widths. It drives the minute strobe as fast as every cycle, so even the longest time-out of 255 minutes fits in a few hundred cycles. This brings the full range within reach, from a one-tick expiry to 255 ticks. It also lets the bench line up exact same-cycle collisions: a reload and a tick together, and a host status write and an expiry together.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int EVT_N  = 3;
  localparam int CFG_W  = 4;
  localparam int ADDR_W = 2;

  // Event vector order matches configuration bits 1..3
  localparam int EV_JOY   = 0;
  localparam int EV_KBD   = 1;
  localparam int EV_MOUSE = 2;
  localparam int CFG_IRQ  = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_VALUE = 2'd0,
    A_CTRL  = 2'd1,
    A_CFG   = 2'd2,
    A_RSVD  = 2'd3
  } wdt_addr_e;

  // Next count on a tick: saturate at zero
  function automatic int unsigned tick_step(int unsigned c);
    return (c == 0) ? 0 : c - 1;
  endfunction

  // A tick at this count expires the watchdog
  function automatic bit is_last(int unsigned c);
    return c == 1;
  endfunction
endpackage

// File: rtl/wdt_evt_detect.sv
module wdt_evt_detect #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  output logic [N-1:0] evt_rise
);
  logic [N-1:0] evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign evt_rise[i] = evt_in[i] & ~evt_q[i];
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              status,
  output logic [CNT_W-1:0]  val_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              val_wr,
  output logic              ctrl_wr,
  output logic [DATA_W-1:0] rdata
);
  logic cfg_wr;

  assign val_wr  = wr && (addr == A_VALUE);
  assign ctrl_wr = wr && (addr == A_CTRL);
  assign cfg_wr  = wr && (addr == A_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      cfg_q <= '0;
    end else begin
      if (val_wr) val_q <= wdata[CNT_W-1:0];
      if (cfg_wr) cfg_q <= wdata[CFG_W-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      A_VALUE: rdata = DATA_W'(val_q);
      A_CTRL:  rdata = DATA_W'(status);
      A_CFG:   rdata = DATA_W'(cfg_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] wval,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ctrl_wr,
  input  logic             ctrl_bit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             status_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_next;

  assign expire = tick && is_last(int'(cnt_q)) && !val_wr && !kick;

  always_comb begin
    if (val_wr)    cnt_next = wval;
    else if (kick) cnt_next = reload_val;
    else if (tick) cnt_next = CNT_W'(tick_step(int'(cnt_q)));
    else           cnt_next = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      if (ctrl_wr)     status_q <= ctrl_bit;
      else if (kick)   status_q <= 1'b0;
      else if (expire) status_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              minute_tick,
  input  logic              kbd_irq,
  input  logic              mouse_irq,
  input  logic              joy_access,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              timeout_status,
  output logic              wdt_irq
);
  logic [EVT_N-1:0] evt_in, evt_rise, evt_en;
  logic [CNT_W-1:0] val_q, cnt_q;
  logic [CFG_W-1:0] cfg_q;
  logic             val_wr, ctrl_wr, kick, expire;

  assign evt_in[EV_JOY]   = joy_access;
  assign evt_in[EV_KBD]   = kbd_irq;
  assign evt_in[EV_MOUSE] = mouse_irq;
  assign evt_en           = cfg_q[EVT_N:1];
  assign kick             = |(evt_rise & evt_en);

  wdt_evt_detect #(.N(EVT_N)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_rise(evt_rise)
  );

  wdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .status(timeout_status), .val_q(val_q),
    .cfg_q(cfg_q), .val_wr(val_wr), .ctrl_wr(ctrl_wr), .rdata(reg_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(minute_tick), .val_wr(val_wr),
    .wval(reg_wdata[CNT_W-1:0]), .kick(kick), .reload_val(val_q),
    .ctrl_wr(ctrl_wr), .ctrl_bit(reg_wdata[0]), .cnt_q(cnt_q),
    .status_q(timeout_status), .expire(expire)
  );

  assign wdt_irq = timeout_status & cfg_q[CFG_IRQ];
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              minute_tick,
  input logic              val_wr,
  input logic              ctrl_wr,
  input logic              kick,
  input logic              expire,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              status,
  input logic              irq,
  input logic              irq_en
);
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (minute_tick && !val_wr && !kick && cnt != 0) |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R1
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && wdata == 0) |=> cnt == 0); // R2
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> cnt == CNT_W'($past(wdata))); // R3
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_wr) |=> status); // R4
  AST_HOST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> status == $past(wdata[0])); // R5
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !ctrl_wr) |=> !status); // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && irq_en)); // R9
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 0 && !val_wr && !kick) |=> cnt == 0); // R10
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .minute_tick(minute_tick), .val_wr(val_wr),
  .ctrl_wr(ctrl_wr), .kick(kick), .expire(expire), .wdata(reg_wdata),
  .cnt(cnt_q), .status(timeout_status), .irq(wdt_irq), .irq_en(cfg_q[0])
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
  logic clk = 0, rst_n = 0;
  logic tick = 0, kbd = 0, mouse = 0, joy = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic stat, irq;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R2";

  // reference model state
  int m_val = 0, m_cfg = 0, m_cnt = 0, m_stat = 0;
  int p_joy = 0, p_kbd = 0, p_mouse = 0;

  always #2 clk = ~clk;

  wdt_top i_wdt_top (
    .clk(clk), .rst_n(rst_n), .minute_tick(tick), .kbd_irq(kbd),
    .mouse_irq(mouse), .joy_access(joy), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .timeout_status(stat), .wdt_irq(irq)
  );

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rd;
    case (addr)
      2'd0: exp_rd = m_val;
      2'd1: exp_rd = m_stat;
      2'd2: exp_rd = m_cfg;
      default: exp_rd = 0;
    endcase
    check("status", int'(stat), m_stat);
    check("irq", int'(irq), (m_stat != 0 && (m_cfg & 1) != 0) ? 1 : 0);
    check("rdata", int'(rdata), exp_rd);
  endtask

  // Apply current inputs for one clock, update model, compare at negedge.
  task automatic step();
    bit rj, rk, rm, kick, vw, cw, fw, ex;
    @(posedge clk);
    rj = joy && !p_joy; rk = kbd && !p_kbd; rm = mouse && !p_mouse;
    kick = (rj && (m_cfg & 2) != 0) || (rk && (m_cfg & 4) != 0) || (rm && (m_cfg & 8) != 0);
    vw = wr && addr == 0; cw = wr && addr == 1; fw = wr && addr == 2;
    ex = !vw && !kick && tick && m_cnt == 1;
    if (cw) m_stat = wdata & 1;
    else if (kick) m_stat = 0;
    else if (ex) m_stat = 1;
    if (vw) m_cnt = wdata;
    else if (kick) m_cnt = m_val;
    else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
    if (vw) m_val = wdata;
    if (fw) m_cfg = wdata & 15;
    p_joy = joy; p_kbd = kbd; p_mouse = mouse;
    @(negedge clk);
    compare();
    wr = 0; tick = 0;
  endtask

  task automatic wreg(int a, int d);
    wr = 1; addr = 2'(a); wdata = 8'(d); step();
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1; step();
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R2"; compare();
    rst_n = 1;
    step(); compare();

    cur_req = "R11";
    wreg(2, 8'hF0); addr = 2; step();
    addr = 3; step();
    wreg(0, 5); addr = 0; step();
    wreg(2, 0);

    cur_req = "R1"; addr = 1;
    wreg(0, 3); ticks(2, 2); ticks(1, 0); step();
    cur_req = "R4"; step();
    cur_req = "R10"; ticks(4, 1);
    wreg(1, 0); ticks(3, 0);

    cur_req = "R3";
    wreg(0, 2); tick = 1; step(); wreg(0, 4); ticks(3, 0); ticks(1, 1);

    cur_req = "R5";
    wreg(0, 9); wreg(1, 1); ticks(2, 0); wreg(1, 0); wreg(1, 1); wreg(1, 0);
    wreg(0, 1); tick = 1; wr = 1; addr = 1; wdata = 0; step(); addr = 1; step();

    cur_req = "R2";
    wreg(0, 3); tick = 1; step(); wreg(0, 0); ticks(6, 0);

    cur_req = "R7";
    wreg(2, 8'h04); wreg(0, 2); tick = 1; step();
    mouse = 1; step(); mouse = 0; ticks(1, 1);
    wreg(0, 2); tick = 1; step(); kbd = 1; step(); kbd = 0;
    ticks(1, 1); ticks(1, 1);
    kbd = 1; step(); kbd = 0; step();

    cur_req = "R6";
    wreg(0, 2); kbd = 1; step(); ticks(2, 1); kbd = 0; ticks(2, 0);

    cur_req = "R8";
    wreg(2, 8'h02); wreg(0, 1); joy = 1; tick = 1; step(); joy = 0; step();
    ticks(1, 0); joy = 1; step(); joy = 0;
    wreg(2, 8'h08); wreg(0, 1); mouse = 1; tick = 1; step(); mouse = 0; ticks(1, 0);
    kbd = 1; joy = 1; ticks(2, 0); kbd = 0; joy = 0;

    cur_req = "R9";
    wreg(2, 8'h09); addr = 2; step(); wreg(2, 8'h08); wreg(1, 1); wreg(2, 8'h01);
    mouse = 1; step(); mouse = 0; wreg(1, 1); wreg(2, 0);

    cur_req = "R10";
    wreg(2, 8'h04); wreg(0, 1); kbd = 1; tick = 1; step(); kbd = 0; ticks(1, 0);

    cur_req = "R1";
    wreg(0, 255); ticks(254, 0); step(); ticks(1, 0); step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule